// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a microcontroller address and its two read strobes into a single active-high chip select. It drives eight primary flash sector selects, four secondary flash sector selects, one SRAM select, one I/O select and one peripheral I/O select. Each select owns an inclusive address window. The bounds come from parameters, so the map is fixed once the design is elaborated.

Windows from different tiers may overlap. A fixed three-tier priority then picks the winner: the SRAM, I/O and peripheral I/O tier first, then secondary flash, then primary flash. A program fetch is marked by the program strobe and a data read by the data strobe. A small run-time map register sets which strobe each of the three memories answers to. The MCU can rewrite that register to rearrange the program and data spaces on the fly.

An elaboration-time check looks for two windows of the same tier that overlap. If it finds one, it flags that tier and removes the tier from the decode.

Top module: `csel_prio_decoder`

## Requirements
- R1: Within each tier, an address between a window's low and high bound, both included, selects that window's output, as long as its memory is enabled for an active strobe and no higher tier claims the address.
- R2: Where a secondary flash window and a primary flash window both match and both qualify, only the secondary select is asserted.
- R3: A qualified SRAM, I/O or peripheral I/O match wins over any qualified flash match at the same address.
- R4: No select is asserted when both strobes are low, or when no qualified window contains the address.
- R5: At most one of the fifteen selects is asserted in any cycle.
- R6: Synchronous reset loads the map register from MAP_INIT. The layout is two bits per memory: SRAM at [1:0], secondary flash at [3:2], primary flash at [5:4]. In each pair, bit 0 enables the program space and bit 1 enables the data space. The default map enables SRAM and primary flash for data, and secondary flash for both spaces.
- R7: When cfg_we is high at a clock edge, cfg_wdata replaces the pair chosen by cfg_addr (0 SRAM, 1 secondary flash, 2 primary flash). The new pair takes effect from that edge on. A write with cfg_addr = 3 changes nothing.
- R8: I/O and peripheral I/O selects answer only while the data strobe is high.
- R9: If two windows of the same tier overlap, that tier's cfg_err bit is high (bit 0 primary, bit 1 secondary, bit 2 top tier). No select of that tier is ever asserted; lower tiers decode as if it matched nothing.
- R10: With the default windows and data strobe, addresses 8000h to 87FFh select SRAM, 8800h to 9FFFh select secondary sector 0, and A000h to BFFFh select primary sector 0.
- R11: The selects are a combinational function of addr, the strobes and the map register. A change on addr or the strobes is visible in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Address from the MCU |
| prog_strobe | input | 1 | Program fetch strobe, active high |
| data_strobe | input | 1 | Data read strobe, active high |
| cfg_we | input | 1 | Map register write enable |
| cfg_addr | input | 2 | Memory chosen for the map write |
| cfg_wdata | input | 2 | {data enable, program enable} for the chosen memory |
| pri_sel | output | NP | Primary flash sector selects |
| sec_sel | output | NS | Secondary flash sector selects |
| sram_sel | output | 1 | SRAM select |
| io_sel | output | 1 | I/O select |
| pio_sel | output | 1 | Peripheral I/O select |
| cfg_err | output | 3 | Same-tier overlap flags |

## Verification
The selects depend only on addr, the strobes and the map register, so they settle in the same cycle the inputs change. The bench drives new inputs just after a rising edge and compares every output with its reference model at the following falling edge. A map write has no effect in the cycle it is presented. It counts only from the next rising edge, so the model updates its copy of the map on that same edge. A second instance with overlapping windows checks the error flags and the tier suppression in the same way.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // Map register entry for one memory
    typedef struct packed {
        logic data_en;
        logic prog_en;
    } space_en_t;

    // Six-bit map register: primary [5:4], secondary [3:2], SRAM [1:0]
    typedef struct packed {
        space_en_t pri;
        space_en_t sec;
        space_en_t sram;
    } space_map_t;

    typedef enum logic [1:0] {
        MEM_SRAM = 2'd0,
        MEM_SEC  = 2'd1,
        MEM_PRI  = 2'd2,
        MEM_NONE = 2'd3
    } mem_id_e;

    // Bit positions in cfg_err
    localparam int ERR_PRI = 0;
    localparam int ERR_SEC = 1;
    localparam int ERR_TOP = 2;
    localparam int NUM_TIERS = 3;

    function automatic logic space_qual(input space_en_t en, input logic p, input logic d);
        return (en.prog_en & p) | (en.data_en & d);
    endfunction

endpackage

// File: rtl/csel_win_bank.sv
module csel_win_bank #(
    parameter int AW = 16,
    parameter int N  = 4,
    parameter logic [N*AW-1:0] LO = '0,
    parameter logic [N*AW-1:0] HI = '0
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  hit,
    output logic          overlap
);

    function automatic logic any_overlap();
        logic found;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if ((LO[i*AW +: AW] <= HI[j*AW +: AW]) &&
                    (LO[j*AW +: AW] <= HI[i*AW +: AW]))
                    found = 1'b1;
            end
        end
        return found;
    endfunction

    localparam logic OVERLAP = any_overlap();

    assign overlap = OVERLAP;

    for (genvar g = 0; g < N; g++) begin : g_win
        localparam logic [AW-1:0] W_LO = LO[g*AW +: AW];
        localparam logic [AW-1:0] W_HI = HI[g*AW +: AW];
        assign hit[g] = (addr >= W_LO) && (addr <= W_HI);
    end

endmodule

// File: rtl/csel_space_map.sv
module csel_space_map
    import csel_pkg::*;
#(
    parameter logic [5:0] MAP_INIT = 6'h2E
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] waddr,
    input  logic [1:0] wdata,
    output space_map_t map_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= space_map_t'(MAP_INIT);
        end else if (we) begin
            case (mem_id_e'(waddr))
                MEM_SRAM: map_q.sram <= space_en_t'(wdata);
                MEM_SEC:  map_q.sec  <= space_en_t'(wdata);
                MEM_PRI:  map_q.pri  <= space_en_t'(wdata);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/csel_prio_resolve.sv
module csel_prio_resolve
    import csel_pkg::*;
#(
    parameter int NP = 8,
    parameter int NS = 4
) (
    input  logic [NP-1:0]        pri_hit,
    input  logic [NS-1:0]        sec_hit,
    input  logic [2:0]           top_hit,
    input  logic                 prog_strobe,
    input  logic                 data_strobe,
    input  space_map_t           map,
    input  logic [NUM_TIERS-1:0] err,
    output logic [NP-1:0]        pri_sel,
    output logic [NS-1:0]        sec_sel,
    output logic [2:0]           top_sel
);

    logic          sram_q, sec_q, pri_q;
    logic [2:0]    top_raw;
    logic [NS-1:0] sec_raw;
    logic [NP-1:0] pri_raw;

    always_comb begin
        sram_q = space_qual(map.sram, prog_strobe, data_strobe);
        sec_q  = space_qual(map.sec,  prog_strobe, data_strobe);
        pri_q  = space_qual(map.pri,  prog_strobe, data_strobe);

        // top tier order: {peripheral I/O, I/O, SRAM}; I/O answers data reads only
        top_raw = top_hit & {data_strobe, data_strobe, sram_q} & {3{~err[ERR_TOP]}};
        sec_raw = sec_hit & {NS{sec_q & ~err[ERR_SEC]}};
        pri_raw = pri_hit & {NP{pri_q & ~err[ERR_PRI]}};

        top_sel = '0;
        sec_sel = '0;
        pri_sel = '0;
        if (|top_raw)      top_sel = top_raw;
        else if (|sec_raw) sec_sel = sec_raw;
        else               pri_sel = pri_raw;
    end

endmodule

// File: rtl/csel_prio_decoder.sv
module csel_prio_decoder
    import csel_pkg::*;
#(
    parameter int AW = 16,
    parameter int NP = 8,
    parameter int NS = 4,
    parameter logic [NP*AW-1:0] PRI_LO = {16'h5000, 16'h4000, 16'h3000, 16'h2000,
                                          16'h1000, 16'h0000, 16'hC000, 16'h8000},
    parameter logic [NP*AW-1:0] PRI_HI = {16'h5FFF, 16'h4FFF, 16'h3FFF, 16'h2FFF,
                                          16'h1FFF, 16'h0FFF, 16'hFFFF, 16'hBFFF},
    parameter logic [NS*AW-1:0] SEC_LO = {16'h7000, 16'h0000, 16'hE000, 16'h8000},
    parameter logic [NS*AW-1:0] SEC_HI = {16'h73FF, 16'h07FF, 16'hEFFF, 16'h9FFF},
    parameter logic [AW-1:0] SRAM_LO = 16'h8000,
    parameter logic [AW-1:0] SRAM_HI = 16'h87FF,
    parameter logic [AW-1:0] IO_LO   = 16'h6000,
    parameter logic [AW-1:0] IO_HI   = 16'h60FF,
    parameter logic [AW-1:0] PIO_LO  = 16'h6100,
    parameter logic [AW-1:0] PIO_HI  = 16'h61FF,
    parameter logic [5:0]    MAP_INIT = 6'h2E
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          prog_strobe,
    input  logic          data_strobe,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [1:0]    cfg_wdata,
    output logic [NP-1:0] pri_sel,
    output logic [NS-1:0] sec_sel,
    output logic          sram_sel,
    output logic          io_sel,
    output logic          pio_sel,
    output logic [2:0]    cfg_err
);

    localparam logic [3*AW-1:0] TOP_LO = {PIO_LO, IO_LO, SRAM_LO};
    localparam logic [3*AW-1:0] TOP_HI = {PIO_HI, IO_HI, SRAM_HI};

    logic [NP-1:0] pri_hit;
    logic [NS-1:0] sec_hit;
    logic [2:0]    top_hit;
    logic [2:0]    top_sel;
    logic          pri_ovl, sec_ovl, top_ovl;
    space_map_t    map_q;

    csel_win_bank #(.AW(AW), .N(NP), .LO(PRI_LO), .HI(PRI_HI)) u_pri_bank (
        .addr(addr), .hit(pri_hit), .overlap(pri_ovl)
    );

    csel_win_bank #(.AW(AW), .N(NS), .LO(SEC_LO), .HI(SEC_HI)) u_sec_bank (
        .addr(addr), .hit(sec_hit), .overlap(sec_ovl)
    );

    csel_win_bank #(.AW(AW), .N(3), .LO(TOP_LO), .HI(TOP_HI)) u_top_bank (
        .addr(addr), .hit(top_hit), .overlap(top_ovl)
    );

    csel_space_map #(.MAP_INIT(MAP_INIT)) u_map (
        .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr),
        .wdata(cfg_wdata), .map_q(map_q)
    );

    always_comb begin
        cfg_err          = '0;
        cfg_err[ERR_PRI] = pri_ovl;
        cfg_err[ERR_SEC] = sec_ovl;
        cfg_err[ERR_TOP] = top_ovl;
    end

    csel_prio_resolve #(.NP(NP), .NS(NS)) u_resolve (
        .pri_hit(pri_hit), .sec_hit(sec_hit), .top_hit(top_hit),
        .prog_strobe(prog_strobe), .data_strobe(data_strobe),
        .map(map_q), .err(cfg_err),
        .pri_sel(pri_sel), .sec_sel(sec_sel), .top_sel(top_sel)
    );

    assign sram_sel = top_sel[0];
    assign io_sel   = top_sel[1];
    assign pio_sel  = top_sel[2];

endmodule

// File: rtl/csel_prio_checker.sv
module csel_prio_checker #(
    parameter int AW = 16,
    parameter int NP = 8,
    parameter int NS = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          prog_strobe,
    input logic          data_strobe,
    input logic          cfg_we,
    input logic [1:0]    cfg_addr,
    input logic [1:0]    cfg_wdata,
    input logic [NP-1:0] pri_sel,
    input logic [NS-1:0] sec_sel,
    input logic          sram_sel,
    input logic          io_sel,
    input logic          pio_sel,
    input logic [2:0]    cfg_err
);

    logic [NP+NS+2:0] all_sel;
    assign all_sel = {pio_sel, io_sel, sram_sel, sec_sel, pri_sel};

    // R5: at most one select
    a_r5_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_sel));

    // R4: no strobe, no select
    a_r4_idle_without_strobe: assert property (@(posedge clk) disable iff (rst)
        (!prog_strobe && !data_strobe) |-> (all_sel == '0));

    // R8: I/O selects need the data strobe
    a_r8_io_data_only: assert property (@(posedge clk) disable iff (rst)
        (io_sel || pio_sel) |-> data_strobe);

    // R7: clearing the SRAM pair removes the SRAM select from the next cycle
    a_r7_sram_cleared: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 2'd0 && cfg_wdata == 2'b00) |=> !sram_sel);

    // R9: a flagged tier never drives a select
    a_r9_pri_suppressed: assert property (@(posedge clk) disable iff (rst)
        cfg_err[0] |-> (pri_sel == '0));

    a_r9_top_suppressed: assert property (@(posedge clk) disable iff (rst)
        cfg_err[2] |-> (!sram_sel && !io_sel && !pio_sel));

    // R11: unchanged inputs and map give unchanged selects
    a_r11_stable: assert property (@(posedge clk) disable iff (rst)
        ($stable(addr) && $stable(prog_strobe) && $stable(data_strobe) && !$past(cfg_we))
        |-> $stable(all_sel));

endmodule

bind csel_prio_decoder csel_prio_checker #(.AW(AW), .NP(NP), .NS(NS)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .prog_strobe(prog_strobe),
    .data_strobe(data_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pri_sel(pri_sel), .sec_sel(sec_sel),
    .sram_sel(sram_sel), .io_sel(io_sel), .pio_sel(pio_sel), .cfg_err(cfg_err)
);

// File: tb/csel_prio_decoder_bench.sv
module csel_prio_decoder_bench;

    localparam logic [127:0] P_LO = {16'h5000, 16'h4000, 16'h3000, 16'h2000,
                                     16'h1000, 16'h0000, 16'hC000, 16'h8000};
    localparam logic [127:0] P_HI = {16'h5FFF, 16'h4FFF, 16'h3FFF, 16'h2FFF,
                                     16'h1FFF, 16'h0FFF, 16'hFFFF, 16'hBFFF};
    localparam logic [127:0] OP_LO = {16'h5000, 16'h4000, 16'h3000, 16'h2000,
                                      16'h1000, 16'h0000, 16'h9000, 16'h8000};
    localparam logic [127:0] OP_HI = {16'h5FFF, 16'h4FFF, 16'h3FFF, 16'h2FFF,
                                      16'h1FFF, 16'h0FFF, 16'hCFFF, 16'hBFFF};
    localparam logic [63:0] S_LO = {16'h7000, 16'h0000, 16'hE000, 16'h8000};
    localparam logic [63:0] S_HI = {16'h73FF, 16'h07FF, 16'hEFFF, 16'h9FFF};
    localparam logic [47:0] T_LO = {16'h6100, 16'h6000, 16'h8000};
    localparam logic [47:0] T_HI = {16'h61FF, 16'h60FF, 16'h87FF};
    localparam logic [47:0] OT_LO = {16'h6100, 16'h8400, 16'h8000};
    localparam logic [47:0] OT_HI = {16'h61FF, 16'h84FF, 16'h87FF};
    localparam logic [5:0] INIT = 6'h2E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h8000;
    logic        prog_strobe = 1'b0;
    logic        data_strobe = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [1:0]  cfg_wdata = 2'd0;
    logic [7:0]  pri_a, pri_b;
    logic [3:0]  sec_a, sec_b;
    logic        sram_a, io_a, pio_a, sram_b, io_b, pio_b;
    logic [2:0]  err_a, err_b;
    logic [5:0]  m = INIT;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    string       tag = "R6";

    always #2 clk = ~clk;

    csel_prio_decoder u_csel_prio_decoder (
        .clk(clk), .rst(rst), .addr(addr), .prog_strobe(prog_strobe),
        .data_strobe(data_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pri_sel(pri_a), .sec_sel(sec_a), .sram_sel(sram_a),
        .io_sel(io_a), .pio_sel(pio_a), .cfg_err(err_a)
    );

    csel_prio_decoder #(
        .PRI_LO(OP_LO), .PRI_HI(OP_HI), .IO_LO(16'h8400), .IO_HI(16'h84FF)
    ) u_csel_prio_decoder_ovl (
        .clk(clk), .rst(rst), .addr(addr), .prog_strobe(prog_strobe),
        .data_strobe(data_strobe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pri_sel(pri_b), .sec_sel(sec_b), .sram_sel(sram_b),
        .io_sel(io_b), .pio_sel(pio_b), .cfg_err(err_b)
    );

    // Map register model (R6, R7)
    always @(posedge clk) begin
        if (rst) m <= INIT;
        else if (cfg_we) begin
            if (cfg_addr == 2'd0) m[1:0] <= cfg_wdata;
            else if (cfg_addr == 2'd1) m[3:2] <= cfg_wdata;
            else if (cfg_addr == 2'd2) m[5:4] <= cfg_wdata;
        end
    end

    function automatic bit ovl(input logic [127:0] lo, input logic [127:0] hi, input int n);
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n; j++)
                if (i != j && lo[i*16 +: 16] <= hi[j*16 +: 16] && lo[j*16 +: 16] <= hi[i*16 +: 16])
                    return 1'b1;
        return 1'b0;
    endfunction

    // Returns {pio, io, sram, sec[3:0], pri[7:0]}
    function automatic logic [14:0] model(input logic [15:0] a, input logic p, input logic d,
                                          input logic [5:0] mp,
                                          input logic [127:0] plo, input logic [127:0] phi,
                                          input logic [47:0] tlo, input logic [47:0] thi);
        logic [14:0] r;
        bit ok_sram, ok_sec, ok_pri;
        r = '0;
        ok_sram = (mp[0] && p) || (mp[1] && d);
        ok_sec  = (mp[2] && p) || (mp[3] && d);
        ok_pri  = (mp[4] && p) || (mp[5] && d);
        if (!ovl({80'h0, tlo}, {80'h0, thi}, 3)) begin
            for (int k = 0; k < 3; k++) begin
                bit ok;
                ok = (k == 0) ? ok_sram : d;
                if (ok && a >= tlo[k*16 +: 16] && a <= thi[k*16 +: 16]) r[12 + k] = 1'b1;
            end
        end
        if (r != 0) return r;
        if (ok_sec && !ovl({64'h0, S_LO}, {64'h0, S_HI}, 4))
            for (int k = 0; k < 4; k++)
                if (a >= S_LO[k*16 +: 16] && a <= S_HI[k*16 +: 16]) r[8 + k] = 1'b1;
        if (r != 0) return r;
        if (ok_pri && !ovl(plo, phi, 8))
            for (int k = 0; k < 8; k++)
                if (a >= plo[k*16 +: 16] && a <= phi[k*16 +: 16]) r[k] = 1'b1;
        return r;
    endfunction

    // Compare both instances at every falling edge (R11: same-cycle response)
    always @(negedge clk) begin
        if (!done) begin
            logic [14:0] ea, eb, ga, gb;
            ea = model(addr, prog_strobe, data_strobe, m, P_LO, P_HI, T_LO, T_HI);
            eb = model(addr, prog_strobe, data_strobe, m, OP_LO, OP_HI, OT_LO, OT_HI);
            ga = {pio_a, io_a, sram_a, sec_a, pri_a};
            gb = {pio_b, io_b, sram_b, sec_b, pri_b};
            checks += 2;
            if (ga !== ea) begin
                errors++;
                $display("FAIL %s addr=%h p=%0d d=%0d actual=%h expected=%h", tag, addr,
                         prog_strobe, data_strobe, ga, ea);
            end
            if (gb !== eb) begin
                errors++;
                $display("FAIL %s (R9 overlap inst) addr=%h actual=%h expected=%h", tag, addr, gb, eb);
            end
        end
    end

    task automatic step(input logic [15:0] a, input logic p, input logic d);
        @(posedge clk);
        #1;
        addr = a; prog_strobe = p; data_strobe = d; cfg_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] ca, input logic [1:0] wd);
        @(posedge clk);
        #1;
        cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = wd;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tag = "R6";
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // R9: overlap flags
        checks += 2;
        if (err_a !== 3'b000) begin
            errors++; $display("FAIL R9 cfg_err actual=%b expected=000", err_a);
        end
        if (err_b !== 3'b101) begin
            errors++; $display("FAIL R9 cfg_err actual=%b expected=101", err_b);
        end

        tag = "R10";
        foreach (addr_list_r10[i]) step(addr_list_r10[i], 1'b0, 1'b1);

        tag = "R1";
        for (int k = 0; k < 8; k++) begin
            step(P_LO[k*16 +: 16], 1'b0, 1'b1);
            step(P_HI[k*16 +: 16], 1'b0, 1'b1);
        end
        for (int k = 0; k < 4; k++) begin
            step(S_LO[k*16 +: 16], 1'b1, 1'b0);
            step(S_HI[k*16 +: 16], 1'b1, 1'b0);
        end

        tag = "R2";
        step(16'hE800, 1'b0, 1'b1);
        step(16'h0400, 1'b0, 1'b1);
        step(16'h8801, 1'b0, 1'b1);

        tag = "R3";
        step(16'h8000, 1'b0, 1'b1);
        step(16'h8400, 1'b0, 1'b1);
        step(16'h6000, 1'b0, 1'b1);
        step(16'h61FF, 1'b0, 1'b1);

        tag = "R4";
        step(16'h8000, 1'b0, 1'b0);
        step(16'hA000, 1'b0, 1'b0);
        step(16'h6800, 1'b0, 1'b1);
        step(16'h7400, 1'b1, 1'b1);

        tag = "R8";
        step(16'h6000, 1'b1, 1'b0);
        step(16'h6100, 1'b1, 1'b0);

        tag = "R7";
        wr(2'd2, 2'b01);
        wr(2'd1, 2'b10);
        step(16'hA000, 1'b1, 1'b0);
        step(16'hA000, 1'b0, 1'b1);
        step(16'h8800, 1'b1, 1'b0);
        step(16'h8800, 1'b0, 1'b1);
        wr(2'd3, 2'b11);
        step(16'hA000, 1'b0, 1'b1);
        wr(2'd0, 2'b00);
        step(16'h8000, 1'b0, 1'b1);
        step(16'h8000, 1'b1, 1'b1);

        tag = "R5";
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            a = $urandom;
            if ($urandom_range(0, 3) == 0) a = {4'h8, 12'h0} | 16'($urandom_range(0, 16'h3FFF));
            if ($urandom_range(0, 9) == 0) wr(2'($urandom), 2'($urandom));
            else step(a, 1'($urandom), 1'($urandom));
        end

        step(16'h0, 1'b0, 1'b0);
        @(posedge clk);
        finish_run();
    end

    logic [15:0] addr_list_r10 [6] = '{16'h8000, 16'h87FF, 16'h8800, 16'h9FFF, 16'hA000, 16'hBFFF};

endmodule